// File: doc/BRIEF.md
# Level-Sensitive Vectored Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines (eight by default), gates them with a software-written mask, and presents one combined interrupt request to the processor. When the processor runs an interrupt-acknowledge cycle, the block hands back a vector byte. That byte is a fixed base of 78h plus the index of the highest-priority unmasked request. Line 0 outranks line 1, line 1 outranks line 2, and so on.

The inputs are levels and nothing more. A request that goes away before it is acknowledged leaves no trace. The controller has no cascade support and the vector base cannot be programmed. Two small registers hold the software view. One is the mask. The other is a read-only copy of the request levels as the block sees them after its input synchroniser.

The winning line is frozen at the first cycle of an acknowledge. After that, request lines may change freely without disturbing the vector the processor is reading. If nothing unmasked is pending when the acknowledge starts, the block answers with the vector of the lowest-priority line.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the mask register reads all ones, `irq_o` is 0, `vec_valid_o` is 0 and `vec_o` is 0.
- R2: `irq_o` is 1 exactly when some request line is 1 and its mask bit is 0. It follows the request lines with a latency of SYNC_STAGES clock cycles (2 by default) and falls once no unmasked line remains.
- R3: A mask bit of 1 removes its line from `irq_o` and from priority resolution. The mask is written with `reg_wr_i`=1 and `reg_addr_i`=0 and is read back on `reg_rdata_o` when `reg_addr_i`=0.
- R4: With `reg_addr_i`=1, `reg_rdata_o` shows the synchronised request levels whatever the mask holds. A write with `reg_addr_i`=1 changes no state, so the mask keeps its value.
- R5: Among the unmasked active lines, the lowest index wins.
- R6: `inta_i` is sampled high at a clock edge while no acknowledge is in progress. From that edge onward, `vec_valid_o` is 1 and `vec_o` equals 78h plus the winning index. This holds until an edge at which `inta_i` is sampled low.
- R7: The winning index is captured at the first acknowledge edge. Request or mask changes during the acknowledge leave `vec_o` unchanged.
- R8: If no unmasked line is active at the first acknowledge edge, `vec_o` is 78h plus NUM_LINES-1 (7Fh by default).
- R9: Requests are level-sensitive only. A line that rises and falls again before an acknowledge is not remembered: `irq_o` returns to 0 and a later acknowledge gets the R8 vector.
- R10: Whenever `vec_valid_o` is 0, `vec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | NUM_LINES | Level request lines, bit i is line i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 mask, 1 level view |
| reg_wdata_i | input | NUM_LINES | Write data for the mask |
| reg_rdata_o | output | NUM_LINES | Read data for the selected register |
| inta_i | input | 1 | Interrupt-acknowledge cycle in progress |
| irq_o | output | 1 | Combined interrupt request to the processor |
| vec_o | output | VEC_W | Vector byte, zero when not valid |
| vec_valid_o | output | 1 | Vector is being driven |

## Verification
The hardest case to reach from the ports is a request pattern that changes in the middle of an acknowledge. To exercise it, the stimulus raises `inta_i` on one line and then, one cycle later, switches the inputs to a pattern whose winner has higher priority. It holds the acknowledge open long enough for that change to pass through the synchroniser, so a design that does not freeze the index would show a different vector before release. The same method produces a spurious acknowledge after a request that has been pulsed and then withdrawn. A scoreboard queue holds the vector the model predicts for each acknowledge, and that entry is compared when `vec_valid_o` rises.

// File: rtl/lvic_pkg.sv
package lvic_pkg;

   // Register select values seen on the register port
   typedef enum logic {
      REG_MASK  = 1'b0,
      REG_LEVEL = 1'b1
   } lvic_reg_e;

   localparam int unsigned LVIC_LINES_DEF   = 8;
   localparam int unsigned LVIC_VEC_W_DEF   = 8;
   localparam int unsigned LVIC_VEC_BASE    = 'h78;
   localparam int unsigned LVIC_SYNC_DEF    = 2;

endpackage

// File: rtl/lvic_sync.sv
// Per-line input synchroniser; zero stages gives a straight wire.
module lvic_sync #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned STAGES    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] raw_i,
   output logic [NUM_LINES-1:0] sync_o
);

   if (STAGES == 0) begin : g_bypass
      assign sync_o = raw_i;
   end else begin : g_chain
      logic [STAGES-1:0][NUM_LINES-1:0] pipe_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe_q <= '0;
         end else begin
            pipe_q[0] <= raw_i;
            for (int s = 1; s < int'(STAGES); s++) begin
               pipe_q[s] <= pipe_q[s-1];
            end
         end
      end

      assign sync_o = pipe_q[STAGES-1];
   end

endmodule

// File: rtl/lvic_regs.sv
// Mask register and read-back multiplexer.
module lvic_regs
   import lvic_pkg::*;
#(
   parameter int unsigned NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_i,
   input  lvic_reg_e            sel_i,
   input  logic [NUM_LINES-1:0] wdata_i,
   input  logic [NUM_LINES-1:0] level_i,
   output logic [NUM_LINES-1:0] mask_o,
   output logic [NUM_LINES-1:0] rdata_o
);

   logic [NUM_LINES-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (wr_i && (sel_i == REG_MASK)) begin
         mask_q <= wdata_i;
      end
   end

   always_comb begin
      unique case (sel_i)
         REG_MASK:  rdata_o = mask_q;
         REG_LEVEL: rdata_o = level_i;
         default:   rdata_o = '0;
      endcase
   end

   assign mask_o = mask_q;

endmodule

// File: rtl/lvic_prio.sv
// Fixed-priority resolver: lowest index wins.
module lvic_prio #(
   parameter int unsigned NUM_LINES = 8,
   localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] active_i,
   output logic [NUM_LINES-1:0] grant_o,
   output logic [IDX_W-1:0]     idx_o,
   output logic                 any_o
);

   // seen[i] is set when some line below i is active
   logic [NUM_LINES:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < int'(NUM_LINES); i++) begin : g_line
      assign grant_o[i]  = active_i[i] & ~seen[i];
      assign seen[i+1]   = seen[i] | active_i[i];
   end

   assign any_o = seen[NUM_LINES];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < int'(NUM_LINES); i++) begin
         if (grant_o[i]) begin
            idx_o = idx_o | IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/lvic_ack.sv
// Captures the winner at the start of an acknowledge and drives the vector.
module lvic_ack #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned VEC_BASE  = 'h78,
   localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inta_i,
   input  logic [IDX_W-1:0] win_idx_i,
   input  logic             win_any_i,
   output logic [VEC_W-1:0] vec_o,
   output logic             vec_valid_o
);

   localparam logic [IDX_W-1:0] IDX_SPURIOUS = IDX_W'(NUM_LINES - 1);
   localparam logic [VEC_W-1:0] BASE_V       = VEC_W'(VEC_BASE);

   logic             busy_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (!inta_i) begin
         busy_q <= 1'b0;
      end else if (!busy_q) begin
         busy_q <= 1'b1;
         idx_q  <= win_any_i ? win_idx_i : IDX_SPURIOUS;
      end
   end

   assign vec_valid_o = busy_q;
   assign vec_o       = busy_q ? (BASE_V + {{(VEC_W-IDX_W){1'b0}}, idx_q}) : '0;

endmodule

// File: rtl/lvl_irq_ctrl.sv
// Level-sensitive vectored interrupt controller, top level.
module lvl_irq_ctrl
   import lvic_pkg::*;
#(
   parameter int unsigned NUM_LINES   = LVIC_LINES_DEF,
   parameter int unsigned VEC_W       = LVIC_VEC_W_DEF,
   parameter int unsigned VEC_BASE    = LVIC_VEC_BASE,
   parameter int unsigned SYNC_STAGES = LVIC_SYNC_DEF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_req_i,
   input  logic                 reg_wr_i,
   input  logic                 reg_addr_i,
   input  logic [NUM_LINES-1:0] reg_wdata_i,
   output logic [NUM_LINES-1:0] reg_rdata_o,
   input  logic                 inta_i,
   output logic                 irq_o,
   output logic [VEC_W-1:0]     vec_o,
   output logic                 vec_valid_o
);

   localparam int unsigned IDX_W = $clog2(NUM_LINES);

   // Elaboration-time parameter checks
   if (NUM_LINES < 2 || NUM_LINES > 256) begin : g_bad_lines
      $error("lvl_irq_ctrl: NUM_LINES must be 2..256");
   end
   if (VEC_W <= IDX_W || VEC_W > 16) begin : g_bad_vec_w
      $error("lvl_irq_ctrl: VEC_W must exceed the index width and be at most 16");
   end
   if ((VEC_BASE + NUM_LINES - 1) >= (1 << VEC_W)) begin : g_bad_base
      $error("lvl_irq_ctrl: vector range does not fit VEC_W");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("lvl_irq_ctrl: SYNC_STAGES must be 0..4");
   end

   logic [NUM_LINES-1:0] level_s;
   logic [NUM_LINES-1:0] mask_q;
   logic [NUM_LINES-1:0] active;
   logic [NUM_LINES-1:0] grant;
   logic [IDX_W-1:0]     win_idx;
   logic                 win_any;

   lvic_sync #(
      .NUM_LINES (NUM_LINES),
      .STAGES    (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (irq_req_i),
      .sync_o (level_s)
   );

   lvic_regs #(
      .NUM_LINES (NUM_LINES)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr_i),
      .sel_i   (lvic_reg_e'(reg_addr_i)),
      .wdata_i (reg_wdata_i),
      .level_i (level_s),
      .mask_o  (mask_q),
      .rdata_o (reg_rdata_o)
   );

   assign active = level_s & ~mask_q;

   lvic_prio #(
      .NUM_LINES (NUM_LINES)
   ) u_prio (
      .active_i (active),
      .grant_o  (grant),
      .idx_o    (win_idx),
      .any_o    (win_any)
   );

   assign irq_o = |active;

   lvic_ack #(
      .NUM_LINES (NUM_LINES),
      .VEC_W     (VEC_W),
      .VEC_BASE  (VEC_BASE)
   ) u_ack (
      .clk         (clk),
      .rst_n       (rst_n),
      .inta_i      (inta_i),
      .win_idx_i   (win_idx),
      .win_any_i   (win_any),
      .vec_o       (vec_o),
      .vec_valid_o (vec_valid_o)
   );

endmodule

// File: rtl/lvic_chk.sv
// Property checker, attached to the top with bind.
module lvic_chk #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned VEC_BASE  = 'h78
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 inta_i,
   input logic                 irq_o,
   input logic [VEC_W-1:0]     vec_o,
   input logic                 vec_valid_o,
   input logic                 reg_wr_i,
   input logic                 reg_addr_i,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_LINES-1:0] active,
   input logic [NUM_LINES-1:0] grant
);

   localparam logic [VEC_W-1:0] V_LO = VEC_W'(VEC_BASE);
   localparam logic [VEC_W-1:0] V_HI = VEC_W'(VEC_BASE + NUM_LINES - 1);

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!vec_valid_o && !irq_o));

   p_irq_vs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (grant != '0));

   p_grant_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & mask_q) == '0);

   p_level_wr_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i) |=> $stable(mask_q));

   p_grant_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~active) == '0));

   p_vec_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |-> (vec_o >= V_LO && vec_o <= V_HI));

   p_valid_needs_inta_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !inta_i |=> !vec_valid_o);

   p_vec_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_o && inta_i) |=> (vec_valid_o && $stable(vec_o)));

   p_vec_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid_o |-> (vec_o == '0));

endmodule

bind lvl_irq_ctrl lvic_chk #(
   .NUM_LINES (NUM_LINES),
   .VEC_W     (VEC_W),
   .VEC_BASE  (VEC_BASE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .inta_i      (inta_i),
   .irq_o       (irq_o),
   .vec_o       (vec_o),
   .vec_valid_o (vec_valid_o),
   .reg_wr_i    (reg_wr_i),
   .reg_addr_i  (reg_addr_i),
   .mask_q      (mask_q),
   .active      (active),
   .grant       (grant)
);

// File: tb/tb_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module tb_lvl_irq_ctrl;

   localparam int N    = 8;
   localparam int VW   = 8;
   localparam int SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_req_i = '0;
   logic          reg_wr_i = 1'b0;
   logic          reg_addr_i = 1'b0;
   logic [N-1:0]  reg_wdata_i = '0;
   logic [N-1:0]  reg_rdata_o;
   logic          inta_i = 1'b0;
   logic          irq_o;
   logic [VW-1:0] vec_o;
   logic          vec_valid_o;

   always #2 clk = ~clk;   // 250 MHz

   lvl_irq_ctrl #(.NUM_LINES(N), .VEC_W(VW), .VEC_BASE('h78), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .reg_wr_i(reg_wr_i),
      .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .inta_i(inta_i), .irq_o(irq_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o));

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Bench model of the software-visible state
   logic [N-1:0] m_lines = '0;
   logic [N-1:0] m_mask  = '1;

   typedef struct { logic [VW-1:0] vec; string req; } exp_t;
   exp_t sb_q[$];
   bit   seen_valid = 1'b0;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [VW-1:0] model_vec(logic [N-1:0] lines, logic [N-1:0] mask);
      logic [N-1:0] act;
      act = lines & ~mask;
      for (int i = 0; i < N; i++) begin
         if (act[i]) return VW'('h78 + i);
      end
      return VW'('h78 + N - 1);
   endfunction

   task automatic set_lines(logic [N-1:0] v);
      @(negedge clk);
      irq_req_i = v;
      m_lines = v;
      repeat (SYNC + 1) @(negedge clk);
   endtask

   task automatic write_reg(logic a, logic [N-1:0] d);
      @(negedge clk);
      reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
      if (a == 1'b0) m_mask = d;
      @(negedge clk);
      reg_wr_i = 1'b0;
   endtask

   task automatic read_reg(logic a, output logic [N-1:0] d);
      @(negedge clk);
      reg_addr_i = a;
      #1;
      d = reg_rdata_o;
   endtask

   // Acknowledge; optional change of request lines after capture
   task automatic do_ack(string req, bit change, logic [N-1:0] new_lines);
      exp_t e;
      e.vec = model_vec(m_lines, m_mask);
      e.req = req;
      sb_q.push_back(e);
      @(negedge clk);
      inta_i = 1'b1;
      @(negedge clk);
      if (change) begin
         irq_req_i = new_lines;
         m_lines = new_lines;
      end
      repeat (SYNC + 2) @(negedge clk);
      #1;
      chk("R7", "vector held", int'(vec_o), int'(e.vec));
      inta_i = 1'b0;
      @(negedge clk);
      #1;
      chk("R10", "valid after release", int'(vec_valid_o), 0);
      chk("R10", "vector after release", int'(vec_o), 0);
   endtask

   // Scoreboard monitor: compares at the first valid cycle of each acknowledge
   always @(negedge clk) begin
      #1;
      if (vec_valid_o && !seen_valid) begin
         if (sb_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R6 unexpected vector actual=%0h expected=none", vec_o);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.req, "ack vector", int'(vec_o), int'(e.vec));
         end
      end
      seen_valid = vec_valid_o;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] rd;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", "irq_o", int'(irq_o), 0);
      chk("R1", "vec_valid_o", int'(vec_valid_o), 0);
      chk("R1", "vec_o", int'(vec_o), 0);
      read_reg(1'b0, rd);
      chk("R1", "mask reset", int'(rd), 'hFF);

      // R3: all masked blocks irq; R4 level view ignores mask
      set_lines(8'h14);
      #1;
      chk("R3", "irq while masked", int'(irq_o), 0);
      read_reg(1'b1, rd);
      chk("R4", "level view", int'(rd), 'h14);

      // R2 / R5 / R6: unmask, line 2 wins
      write_reg(1'b0, 8'h00);
      #1;
      chk("R2", "irq unmasked", int'(irq_o), 1);
      do_ack("R5", 1'b0, '0);

      // R3: mask line 2, line 4 wins
      write_reg(1'b0, 8'h04);
      read_reg(1'b0, rd);
      chk("R3", "mask readback", int'(rd), 'h04);
      do_ack("R3", 1'b0, '0);

      // R8: every active line masked -> spurious vector
      write_reg(1'b0, 8'h14);
      #1;
      chk("R3", "irq all active masked", int'(irq_o), 0);
      do_ack("R8", 1'b0, '0);

      // R4: write to level register ignored
      write_reg(1'b1, 8'h00);
      read_reg(1'b0, rd);
      chk("R4", "mask after level write", int'(rd), 'h14);
      read_reg(1'b1, rd);
      chk("R4", "level after level write", int'(rd), 'h14);

      // R6: each line alone gives base plus index
      write_reg(1'b0, 8'h00);
      for (int i = 0; i < N; i++) begin
         set_lines(N'(1) << i);
         do_ack("R6", 1'b0, '0);
      end
      set_lines(8'hFF);
      do_ack("R5", 1'b0, '0);

      // R7: higher-priority request arrives during the acknowledge
      set_lines(8'h40);
      do_ack("R7", 1'b1, 8'h01);
      repeat (SYNC + 1) @(negedge clk);

      // R2 latency and drop
      set_lines(8'h00);
      @(negedge clk);
      irq_req_i = 8'h02; m_lines = 8'h02;
      @(negedge clk); #1;
      chk("R2", "irq before latency", int'(irq_o), 0);
      @(negedge clk); #1;
      chk("R2", "irq after latency", int'(irq_o), 1);
      irq_req_i = 8'h00; m_lines = 8'h00;
      repeat (SYNC) @(negedge clk);
      #1;
      chk("R2", "irq drops", int'(irq_o), 0);

      // R9: pulse withdrawn before acknowledge is forgotten
      set_lines(8'h08);
      set_lines(8'h00);
      #1;
      chk("R9", "irq after withdrawn pulse", int'(irq_o), 0);
      do_ack("R9", 1'b0, '0);

      repeat (3) @(negedge clk);
      chk("R6", "scoreboard drained", sb_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule